// File: doc/BRIEF.md
# OTP Programming Sequencer Register

This block is a single control register on a CPU register bus that guards writes into one-time-programmable memory. It holds two control bits: a bus-hold bit that freezes an array address and data word for programming and shuts off normal array reads, and a supply bit that switches the programming voltage onto the array. The block enforces the order in which the two bits may be turned on, so that the programming supply can only be applied once the address and data are already held.

The register's state is kept in a small state machine with three named states: `ST_IDLE` (both bits clear), `ST_ARMED` (hold bit set, supply off) and `ST_POWERED` (both set). The transitions are `T_ARM` (IDLE to ARMED, any register write with the hold bit at 1), `T_POWER_ON` (ARMED to POWERED, write with hold 1 and supply 1), `T_POWER_OFF` (POWERED to ARMED, write with hold 1 and supply 0), `T_DISARM` (ARMED to IDLE, write with hold 0) and `T_DROP` (POWERED to IDLE, write with hold 0). Every other write leaves the state unchanged. The `T_ARM` write also loads the holding registers from the presented programming address and data.

Software arms the register, then turns on the supply with a later write. When it clears the hold bit, the supply drops in the same cycle. The bus read path answers with either the register view or array data. While the hold bit is set, array reads are blocked and return zero.

Top module: `otp_prog_ctrl`

## Requirements
- R1: After synchronous reset the register reads 0x00, and `vpp_en`, `latch_active` and both holding registers are 0.
- R2: A read at address 0x1C returns the hold bit in bit 2, the supply bit in bit 0, and 0 in bits 7..3 and bit 1.
- R3: A register write with bit 0 set turns the supply on only if the hold bit was already 1 before that write; from IDLE, writing 0x01 leaves the register at 0x00.
- R4: A single write of 0x05 while the hold bit is 0 sets the hold bit and leaves the supply bit at 0 (register reads 0x04).
- R5: Any write with bit 2 at 0 clears the hold bit and the supply bit together at the same clock edge.
- R6: Written values in bits 7..3 and bit 1 have no effect: writing 0xFA from IDLE reads back 0x00, and writing 0xFF from ARMED reads back 0x05.
- R7: While the hold bit is 1, a read inside the array window (0x0100..0x17FF) returns 0x00, asserts `arr_rd_blocked` and keeps `arr_re` low.
- R8: While the hold bit is 0, a read inside the array window forwards `arr_rdata` to `bus_rdata`, asserts `arr_re` and keeps `arr_rd_blocked` low.
- R9: The write that moves IDLE to ARMED loads `hold_addr`/`hold_data` from `pgm_addr`/`pgm_data`; they stay frozen while the hold bit remains 1 and reload only on the next arming write.
- R10: `vpp_en` equals the supply bit, `latch_active` equals the hold bit, and `vpp_en` is never 1 while `latch_active` is 0.
- R11: Writes to any address other than 0x1C leave the register state unchanged.
- R12: From POWERED, a write of 0x04 turns the supply off and keeps the hold bit (register reads 0x04).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 13 | CPU bus address |
| bus_wdata | input | 8 | CPU write data |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 8 | Read data (register view, array data or zero) |
| pgm_addr | input | 13 | Array address presented for programming |
| pgm_data | input | 8 | Data word presented for programming |
| arr_rdata | input | 8 | Data returned by the array |
| arr_re | output | 1 | Read strobe forwarded to the array |
| arr_rd_blocked | output | 1 | High during an array read refused because the hold bit is set |
| hold_addr | output | 13 | Frozen programming address |
| hold_data | output | 8 | Frozen programming data |
| latch_active | output | 1 | Hold bit; array paths configured for programming |
| vpp_en | output | 1 | Programming-voltage enable |

## Verification
The bench goes after the ordering interlock. A combined 0x05 write from IDLE must give 0x04, and a design that honoured both bits would read 0x05 with `vpp_en` high. A lone 0x01 from IDLE must stay at zero, and an unguarded supply bit would turn on. Clearing the hold bit from POWERED must drop the supply at the same edge, and a design that forgot this would leave `vpp_en` high with no held address. The bench also checks that the holding registers are not reloaded by the power-on write, that array reads return zero only while the hold bit is set, and that writes to neighbouring addresses and to reserved bit positions leave the readback unchanged.

// File: rtl/otp_prog_pkg.sv
package otp_prog_pkg;

    // Register state: hold bit and supply bit combinations that are legal
    typedef enum logic [1:0] {
        ST_IDLE    = 2'b00,
        ST_ARMED   = 2'b01,
        ST_POWERED = 2'b11
    } prog_state_e;

    // Bit positions decoded by software
    localparam int LATCH_BIT = 2;
    localparam int PWR_BIT   = 0;

endpackage

// File: rtl/otp_prog_fsm.sv
module otp_prog_fsm
    import otp_prog_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic reg_wr,
    input  logic wr_latch,
    input  logic wr_pwr,
    output logic latch_o,
    output logic pwr_o,
    output logic capture_o
);

    prog_state_e state_q, state_d;

    // State register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                // T_ARM: supply request ignored on the arming write
                if (reg_wr && wr_latch) state_d = ST_ARMED;
            end
            ST_ARMED: begin
                if (reg_wr) begin
                    if (!wr_latch)   state_d = ST_IDLE;     // T_DISARM
                    else if (wr_pwr) state_d = ST_POWERED;  // T_POWER_ON
                end
            end
            ST_POWERED: begin
                if (reg_wr) begin
                    if (!wr_latch)    state_d = ST_IDLE;    // T_DROP
                    else if (!wr_pwr) state_d = ST_ARMED;   // T_POWER_OFF
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        latch_o   = 1'b0;
        pwr_o     = 1'b0;
        capture_o = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                capture_o = reg_wr && wr_latch;
            end
            ST_ARMED: begin
                latch_o = 1'b1;
            end
            ST_POWERED: begin
                latch_o = 1'b1;
                pwr_o   = 1'b1;
            end
            default: begin
                latch_o = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/otp_hold_regs.sv
module otp_hold_regs #(
    parameter int ADDR_W = 13,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] data_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic [DATA_W-1:0] data_o
);

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_o <= '0;
            data_o <= '0;
        end else if (load) begin
            addr_o <= addr_i;
            data_o <= data_i;
        end
    end

endmodule

// File: rtl/otp_read_mux.sv
module otp_read_mux
    import otp_prog_pkg::*;
#(
    parameter int                ADDR_W   = 13,
    parameter int                DATA_W   = 8,
    parameter logic [ADDR_W-1:0] REG_ADDR = 'h1C,
    parameter logic [ADDR_W-1:0] ARR_LO   = 'h0100,
    parameter logic [ADDR_W-1:0] ARR_HI   = 'h17FF
) (
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_re,
    input  logic              latch,
    input  logic              pwr,
    input  logic [DATA_W-1:0] arr_rdata,
    output logic [DATA_W-1:0] rdata,
    output logic              arr_re,
    output logic              blocked
);

    logic [DATA_W-1:0] reg_view;
    logic              reg_hit, arr_hit;

    // Register view: live bits at their positions, zeros elsewhere
    for (genvar i = 0; i < DATA_W; i++) begin : g_view
        if (i == LATCH_BIT) begin : g_latch
            assign reg_view[i] = latch;
        end else if (i == PWR_BIT) begin : g_pwr
            assign reg_view[i] = pwr;
        end else begin : g_rsvd
            assign reg_view[i] = 1'b0;
        end
    end

    assign reg_hit = (bus_addr == REG_ADDR);
    assign arr_hit = (bus_addr >= ARR_LO) && (bus_addr <= ARR_HI);

    always_comb begin
        rdata   = '0;
        arr_re  = 1'b0;
        blocked = 1'b0;
        if (bus_re) begin
            if (reg_hit) begin
                rdata = reg_view;
            end else if (arr_hit) begin
                if (latch) begin
                    blocked = 1'b1;
                end else begin
                    arr_re = 1'b1;
                    rdata  = arr_rdata;
                end
            end
        end
    end

endmodule

// File: rtl/otp_prog_ctrl.sv
module otp_prog_ctrl
    import otp_prog_pkg::*;
#(
    parameter int                ADDR_W   = 13,
    parameter int                DATA_W   = 8,
    parameter logic [ADDR_W-1:0] REG_ADDR = 'h1C,
    parameter logic [ADDR_W-1:0] ARR_LO   = 'h0100,
    parameter logic [ADDR_W-1:0] ARR_HI   = 'h17FF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_we,
    input  logic              bus_re,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [ADDR_W-1:0] pgm_addr,
    input  logic [DATA_W-1:0] pgm_data,
    input  logic [DATA_W-1:0] arr_rdata,
    output logic              arr_re,
    output logic              arr_rd_blocked,
    output logic [ADDR_W-1:0] hold_addr,
    output logic [DATA_W-1:0] hold_data,
    output logic              latch_active,
    output logic              vpp_en
);

    localparam logic [DATA_W-1:0] USED_MASK =
        DATA_W'((1 << LATCH_BIT) | (1 << PWR_BIT));

    logic reg_wr, capture, latch, pwr;
    logic unused_rsvd_bits;

    assign reg_wr           = bus_we && (bus_addr == REG_ADDR);
    assign unused_rsvd_bits = ^(bus_wdata & ~USED_MASK);

    otp_prog_fsm u_fsm (
        .clk      (clk),
        .rst      (rst),
        .reg_wr   (reg_wr),
        .wr_latch (bus_wdata[LATCH_BIT]),
        .wr_pwr   (bus_wdata[PWR_BIT]),
        .latch_o  (latch),
        .pwr_o    (pwr),
        .capture_o(capture)
    );

    otp_hold_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_hold (
        .clk   (clk),
        .rst   (rst),
        .load  (capture),
        .addr_i(pgm_addr),
        .data_i(pgm_data),
        .addr_o(hold_addr),
        .data_o(hold_data)
    );

    otp_read_mux #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W),
        .REG_ADDR(REG_ADDR), .ARR_LO(ARR_LO), .ARR_HI(ARR_HI)
    ) u_rd (
        .bus_addr (bus_addr),
        .bus_re   (bus_re),
        .latch    (latch),
        .pwr      (pwr),
        .arr_rdata(arr_rdata),
        .rdata    (bus_rdata),
        .arr_re   (arr_re),
        .blocked  (arr_rd_blocked)
    );

    assign latch_active = latch;
    assign vpp_en       = pwr;

endmodule

// File: rtl/otp_prog_chk.sv
module otp_prog_chk #(
    parameter int                ADDR_W   = 13,
    parameter int                DATA_W   = 8,
    parameter logic [ADDR_W-1:0] REG_ADDR = 'h1C,
    parameter logic [ADDR_W-1:0] ARR_LO   = 'h0100,
    parameter logic [ADDR_W-1:0] ARR_HI   = 'h17FF
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              bus_we,
    input logic              bus_re,
    input logic [DATA_W-1:0] bus_rdata,
    input logic [DATA_W-1:0] arr_rdata,
    input logic              arr_re,
    input logic              arr_rd_blocked,
    input logic [ADDR_W-1:0] hold_addr,
    input logic [DATA_W-1:0] hold_data,
    input logic              latch_active,
    input logic              vpp_en
);

    logic reg_wr, arr_hit;
    assign reg_wr  = bus_we && (bus_addr == REG_ADDR);
    assign arr_hit = (bus_addr >= ARR_LO) && (bus_addr <= ARR_HI);

    a_r3_power_after_latch: assert property (@(posedge clk) disable iff (rst)
        $rose(vpp_en) |-> $past(latch_active));

    a_r4_no_dual_set: assert property (@(posedge clk) disable iff (rst)
        (!latch_active && reg_wr && bus_wdata[2] && bus_wdata[0])
        |=> (latch_active && !vpp_en));

    a_r5_drop_clears_power: assert property (@(posedge clk) disable iff (rst)
        $fell(latch_active) |-> !vpp_en);

    a_r7_blocked_read: assert property (@(posedge clk) disable iff (rst)
        (bus_re && arr_hit && latch_active)
        |-> (bus_rdata == '0 && arr_rd_blocked && !arr_re));

    a_r8_open_read: assert property (@(posedge clk) disable iff (rst)
        (bus_re && arr_hit && !latch_active)
        |-> (bus_rdata == arr_rdata && arr_re && !arr_rd_blocked));

    a_r9_hold_frozen: assert property (@(posedge clk) disable iff (rst)
        (latch_active && $past(latch_active))
        |-> ($stable(hold_addr) && $stable(hold_data)));

    a_r10_power_implies_latch: assert property (@(posedge clk) disable iff (rst)
        vpp_en |-> latch_active);

    a_r11_no_write_no_change: assert property (@(posedge clk) disable iff (rst)
        !reg_wr |=> ($stable(latch_active) && $stable(vpp_en)));

endmodule

bind otp_prog_ctrl otp_prog_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .REG_ADDR(REG_ADDR), .ARR_LO(ARR_LO), .ARR_HI(ARR_HI)
) u_chk (
    .clk           (clk),
    .rst           (rst),
    .bus_addr      (bus_addr),
    .bus_wdata     (bus_wdata),
    .bus_we        (bus_we),
    .bus_re        (bus_re),
    .bus_rdata     (bus_rdata),
    .arr_rdata     (arr_rdata),
    .arr_re        (arr_re),
    .arr_rd_blocked(arr_rd_blocked),
    .hold_addr     (hold_addr),
    .hold_data     (hold_data),
    .latch_active  (latch_active),
    .vpp_en        (vpp_en)
);

// File: tb/test_otp_prog_ctrl.sv
module test_otp_prog_ctrl;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [12:0] bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic        bus_we = 1'b0;
    logic        bus_re = 1'b0;
    logic [7:0]  bus_rdata;
    logic [12:0] pgm_addr = '0;
    logic [7:0]  pgm_data = '0;
    logic [7:0]  arr_rdata = '0;
    logic        arr_re, arr_rd_blocked, latch_active, vpp_en;
    logic [12:0] hold_addr;
    logic [7:0]  hold_data;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    otp_prog_ctrl i_otp_prog_ctrl (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata),
        .pgm_addr(pgm_addr), .pgm_data(pgm_data), .arr_rdata(arr_rdata),
        .arr_re(arr_re), .arr_rd_blocked(arr_rd_blocked),
        .hold_addr(hold_addr), .hold_data(hold_data),
        .latch_active(latch_active), .vpp_en(vpp_en)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [12:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [12:0] a, output logic [7:0] d,
                      output logic re_o, output logic blk_o);
        @(negedge clk);
        bus_addr = a; bus_re = 1'b1;
        #1;
        d = bus_rdata; re_o = arr_re; blk_o = arr_rd_blocked;
        bus_re = 1'b0;
    endtask

    task automatic rd_reg(output logic [7:0] d);
        logic r, b;
        rd(13'h1C, d, r, b);
    endtask

    task automatic t_reset();
        logic [7:0] d;
        rd_reg(d);
        check("R1 reg", d, 8'h00);
        check("R1 vpp", vpp_en, 1'b0);
        check("R1 latch", latch_active, 1'b0);
        check("R1 hold", {hold_addr, hold_data}, '0);
    endtask

    task automatic t_format();
        logic [7:0] d;
        wr(13'h1C, 8'hFA); rd_reg(d);
        check("R6 rsvd from idle", d, 8'h00);
        wr(13'h1C, 8'h04); rd_reg(d);
        check("R2 latch at bit2", d, 8'h04);
        wr(13'h1C, 8'hFF); rd_reg(d);
        check("R2/R6 both bits, rsvd zero", d, 8'h05);
        wr(13'h1C, 8'h00); rd_reg(d);
        check("R5 clear", d, 8'h00);
    endtask

    task automatic t_power_needs_latch();
        logic [7:0] d;
        wr(13'h1C, 8'h01); rd_reg(d);
        check("R3 power w/o latch", d, 8'h00);
        check("R3 vpp", vpp_en, 1'b0);
    endtask

    task automatic t_dual_set();
        logic [7:0] d;
        wr(13'h1C, 8'h05); rd_reg(d);
        check("R4 dual set", d, 8'h04);
        check("R4 vpp", vpp_en, 1'b0);
        wr(13'h1C, 8'h05); rd_reg(d);
        check("R3 second write powers", d, 8'h05);
        check("R10 vpp follows bit", vpp_en, 1'b1);
        check("R10 latch follows bit", latch_active, 1'b1);
    endtask

    task automatic t_drop();
        logic [7:0] d;
        wr(13'h1C, 8'h00); rd_reg(d);
        check("R5 drop reg", d, 8'h00);
        check("R5 drop vpp", vpp_en, 1'b0);
        wr(13'h1C, 8'h01); rd_reg(d);
        check("R3 after drop", d, 8'h00);
    endtask

    task automatic t_power_off();
        logic [7:0] d;
        wr(13'h1C, 8'h04); wr(13'h1C, 8'h05); wr(13'h1C, 8'h04); rd_reg(d);
        check("R12 power off", d, 8'h04);
        check("R12 vpp", vpp_en, 1'b0);
        wr(13'h1C, 8'h00);
    endtask

    task automatic t_array();
        logic [7:0] d;
        logic r, b;
        arr_rdata = 8'hA5;
        rd(13'h0200, d, r, b);
        check("R8 data", d, 8'hA5);
        check("R8 re/blk", {r, b}, 2'b10);
        wr(13'h1C, 8'h04);
        rd(13'h0200, d, r, b);
        check("R7 data", d, 8'h00);
        check("R7 re/blk", {r, b}, 2'b01);
        wr(13'h1C, 8'h00);
        rd(13'h17FF, d, r, b);
        check("R8 top of window", d, 8'hA5);
    endtask

    task automatic t_capture();
        pgm_addr = 13'h0345; pgm_data = 8'h3C;
        wr(13'h1C, 8'h04);
        check("R9 capture", {hold_addr, hold_data}, {13'h0345, 8'h3C});
        pgm_addr = 13'h0777; pgm_data = 8'h81;
        wr(13'h1C, 8'h05);
        check("R9 frozen", {hold_addr, hold_data}, {13'h0345, 8'h3C});
        wr(13'h1C, 8'h00);
        check("R9 kept after clear", {hold_addr, hold_data}, {13'h0345, 8'h3C});
        wr(13'h1C, 8'h04);
        check("R9 recapture", {hold_addr, hold_data}, {13'h0777, 8'h81});
        wr(13'h1C, 8'h00);
    endtask

    task automatic t_other_addr();
        logic [7:0] d;
        wr(13'h1B, 8'h04);
        check("R11 idle other addr", latch_active, 1'b0);
        wr(13'h1C, 8'h04);
        wr(13'h1D, 8'h00);
        rd_reg(d);
        check("R11 armed other addr", d, 8'h04);
        wr(13'h1C, 8'h00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_format();
        t_power_needs_latch();
        t_dual_set();
        t_drop();
        t_power_off();
        t_array();
        t_capture();
        t_other_addr();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        #400000;
        if (!done) begin
            done = 1'b1;
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule